// File: doc/BRIEF.md
# Tagged FIFO Communication Cell

One shared storage cell that hardware threads use as a small queue of 64-bit words. Every request names a requester, a view code, a read/write direction and a data word. The view code chooses how the access acts on the cell. The bypass view inspects or patches the queue without moving it. The control view reads or sets the status tag. The two empty/full views push and pop, one blocking and one non-blocking.

A blocking access that cannot proceed is answered with a stall, and the block records the requester in a wait mask. The next empty/full access that does not stall hands the whole wait mask to the thread scheduler as a one-cycle wake pulse and clears it. The scheduler outside the block then retries those threads.

Top module: `tfifo_cell`

## Requirements
- R1: After reset the queue is empty, every entry is zero, the empty flag is 1, the full and trap flags are 0, no wait bits are set, and the outputs rsp_valid, rsp_stall, rsp_error and wake_mask are all 0.
- R2: A control-view (code 1) read returns the tag word. Empty is in bit 0, full in bit 1, trap in bit 16, a constant 1 queue flag in bit 17, the occupancy in bits 18 up, and log2(DEPTH) in bits 28 up. All other bits are 0.
- R3: A control-view write copies bits 16, 0 and 1 of the data into trap, empty and full. Occupancy, head and entries stay unchanged.
- R4: A bypass-view (code 0) read returns the entry at the head and does not pop it.
- R5: A bypass-view write replaces the entry at (head + occupancy − 1) mod DEPTH when the occupancy is non-zero. When the occupancy is zero the write is ignored.
- R6: A non-stalled empty/full read (code 2 or 3) with non-zero occupancy returns the head entry. The head then advances modulo DEPTH, the occupancy drops by one and full is cleared. After any such read, empty is set if the occupancy is zero.
- R7: A non-stalled empty/full write with occupancy below DEPTH stores the data at (head + occupancy) mod DEPTH, raises the occupancy and clears empty. After any such write, full is set if the occupancy equals DEPTH.
- R8: A blocking read (code 2) stalls when empty is 1, and a blocking write stalls when full is 1. A stall answers with rsp_stall = 1 and zero data, sets bit req_id of the wait mask, and changes nothing else.
- R9: Every non-stalled empty/full access puts the wait mask as it stood before the access on wake_mask for exactly one cycle, then clears the mask. wake_mask is 0 at all other times.
- R10: A non-blocking read (code 3) at zero occupancy returns 0 and pops nothing. A non-blocking write at occupancy DEPTH is dropped. Neither one stalls.
- R11: View codes 4 to 15 answer with rsp_error = 1. Reads return 0 and writes are ignored.
- R12: Each request with req_valid = 1 gets exactly one response with rsp_valid = 1 in the next cycle. Tag and entry updates take effect at that same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_id | input | $clog2(MASK_W) | Requester number |
| req_view | input | 4 | View code: 0 bypass, 1 control, 2 blocking empty/full, 3 non-blocking empty/full |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 64 | Read data, 0 for writes, stalls and errors |
| rsp_stall | output | 1 | Request stalled and recorded in the wait mask |
| rsp_error | output | 1 | Unsupported view code |
| wake_mask | output | MASK_W | One-cycle pulse of the released requesters |

## Verification
Every result is registered once. The response fields and the wake pulse for a request made in cycle N appear in cycle N+1. The tag change caused by that request first shows in the response to a request made in cycle N+1. The bench drives each request on a falling edge and compares all outputs on the next falling edge, which is one rising edge later. Its reference model advances one request per comparison, so results from back-to-back requests are never read out of order.

// File: rtl/tfifo_pkg.sv
package tfifo_pkg;

    localparam int WORD_W     = 64;
    localparam int VIEW_W     = 4;
    localparam int POS_E      = 0;
    localparam int POS_F      = 1;
    localparam int POS_T      = 16;
    localparam int POS_QFLAG  = 17;
    localparam int POS_PTR    = 18;
    localparam int PTR_FLD_W  = 10;
    localparam int POS_CODE   = 28;
    localparam int CODE_FLD_W = 8;

    localparam logic [VIEW_W-1:0] VC_BYPASS  = 4'd0;
    localparam logic [VIEW_W-1:0] VC_CTRL    = 4'd1;
    localparam logic [VIEW_W-1:0] VC_EF_WAIT = 4'd2;
    localparam logic [VIEW_W-1:0] VC_EF_TRY  = 4'd3;

    typedef enum logic [1:0] {
        ACT_BYPASS,
        ACT_CTRL,
        ACT_EF,
        ACT_NONE
    } act_kind_e;

    typedef struct packed {
        act_kind_e kind;
        logic      blocking;
        logic      bad;
    } act_t;

    typedef struct packed {
        logic t;
        logic e;
        logic f;
    } flags_t;

    function automatic logic [WORD_W-1:0] pack_ctrl(
        input flags_t                fl,
        input logic [PTR_FLD_W-1:0]  p,
        input logic [CODE_FLD_W-1:0] c
    );
        logic [WORD_W-1:0] w;
        w = '0;
        w[POS_E]                 = fl.e;
        w[POS_F]                 = fl.f;
        w[POS_T]                 = fl.t;
        w[POS_QFLAG]             = 1'b1;
        w[POS_PTR +: PTR_FLD_W]  = p;
        w[POS_CODE +: CODE_FLD_W] = c;
        return w;
    endfunction

endpackage

// File: rtl/tfifo_view_dec.sv
module tfifo_view_dec
    import tfifo_pkg::*;
(
    input  logic [VIEW_W-1:0] view,
    output act_t              act
);
    always_comb begin
        act = '{kind: ACT_NONE, blocking: 1'b0, bad: 1'b1};
        case (view)
            VC_BYPASS:  act = '{kind: ACT_BYPASS, blocking: 1'b0, bad: 1'b0};
            VC_CTRL:    act = '{kind: ACT_CTRL,   blocking: 1'b0, bad: 1'b0};
            VC_EF_WAIT: act = '{kind: ACT_EF,     blocking: 1'b1, bad: 1'b0};
            VC_EF_TRY:  act = '{kind: ACT_EF,     blocking: 1'b0, bad: 1'b0};
            default:    act = '{kind: ACT_NONE,   blocking: 1'b0, bad: 1'b1};
        endcase
    end
endmodule

// File: rtl/tfifo_store.sv
module tfifo_store #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[widx] <= wdata;
        end
    end

    assign rdata = mem_q[ridx];
endmodule

// File: rtl/tfifo_waitmask.sv
module tfifo_waitmask #(
    parameter int MASK_W = 64,
    localparam int ID_W  = $clog2(MASK_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic              go,
    input  logic [ID_W-1:0]   id,
    output logic [MASK_W-1:0] mask_q,
    output logic [MASK_W-1:0] wake_q
);
    logic [MASK_W-1:0] mask_d;

    always_comb begin
        mask_d = mask_q;
        if (go)         mask_d = '0;
        else if (stall) mask_d[id] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            wake_q <= '0;
        end else begin
            mask_q <= mask_d;
            wake_q <= go ? mask_q : '0;
        end
    end
endmodule

// File: rtl/tfifo_cell.sv
module tfifo_cell
    import tfifo_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int MASK_W = 64,
    localparam int ID_W  = $clog2(MASK_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ID_W-1:0]   req_id,
    input  logic [VIEW_W-1:0] req_view,
    input  logic              req_write,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              rsp_stall,
    output logic              rsp_error,
    output logic [MASK_W-1:0] wake_mask
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = $clog2(DEPTH + 1);
    localparam logic [CODE_FLD_W-1:0] DCODE = CODE_FLD_W'($clog2(DEPTH));

    act_t               act;
    flags_t             flg_q, flg_d;
    logic [IDX_W-1:0]   head_q, head_d, widx;
    logic [PTR_W-1:0]   ptr_q, ptr_d;
    logic [WORD_W-1:0]  head_word, rd_d;
    logic [MASK_W-1:0]  blk_mask;
    logic               ef_acc, stall, go, pop, push, byp_wr, ctl_wr;
    logic               not_empty, not_full;

    tfifo_view_dec u_dec (.view(req_view), .act(act));

    assign not_empty = (ptr_q != '0);
    assign not_full  = (32'(ptr_q) < DEPTH);
    assign ef_acc    = req_valid && (act.kind == ACT_EF);
    assign stall     = ef_acc && act.blocking && (req_write ? flg_q.f : flg_q.e);
    assign go        = ef_acc && !stall;
    assign pop       = go && !req_write && not_empty;
    assign push      = go && req_write && not_full;
    assign byp_wr    = req_valid && (act.kind == ACT_BYPASS) && req_write && not_empty;
    assign ctl_wr    = req_valid && (act.kind == ACT_CTRL) && req_write;
    assign widx      = IDX_W'(32'(head_q) + 32'(ptr_q) - (push ? 32'd0 : 32'd1));

    tfifo_store #(.DEPTH(DEPTH), .DATA_W(WORD_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (push || byp_wr),
        .widx  (widx),
        .wdata (req_wdata),
        .ridx  (head_q),
        .rdata (head_word)
    );

    tfifo_waitmask #(.MASK_W(MASK_W)) u_wait (
        .clk    (clk),
        .rst    (rst),
        .stall  (stall),
        .go     (go),
        .id     (req_id),
        .mask_q (blk_mask),
        .wake_q (wake_mask)
    );

    always_comb begin
        flg_d  = flg_q;
        head_d = head_q;
        ptr_d  = ptr_q;
        if (ctl_wr) begin
            flg_d.t = req_wdata[POS_T];
            flg_d.e = req_wdata[POS_E];
            flg_d.f = req_wdata[POS_F];
        end
        if (pop) begin
            head_d  = head_q + IDX_W'(1);
            ptr_d   = ptr_q - PTR_W'(1);
            flg_d.f = 1'b0;
        end
        if (push) begin
            ptr_d   = ptr_q + PTR_W'(1);
            flg_d.e = 1'b0;
        end
        if (go && !req_write && (ptr_d == '0))        flg_d.e = 1'b1;
        if (go && req_write && (32'(ptr_d) == DEPTH)) flg_d.f = 1'b1;
    end

    always_comb begin
        rd_d = '0;
        case (act.kind)
            ACT_BYPASS: if (!req_write) rd_d = head_word;
            ACT_CTRL:   if (!req_write) rd_d = pack_ctrl(flg_q, PTR_FLD_W'(ptr_q), DCODE);
            ACT_EF:     if (pop)        rd_d = head_word;
            default:    rd_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flg_q     <= '{t: 1'b0, e: 1'b1, f: 1'b0};
            head_q    <= '0;
            ptr_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_stall <= 1'b0;
            rsp_error <= 1'b0;
        end else begin
            flg_q     <= flg_d;
            head_q    <= head_d;
            ptr_q     <= ptr_d;
            rsp_valid <= req_valid;
            rsp_rdata <= req_valid ? rd_d : '0;
            rsp_stall <= stall;
            rsp_error <= req_valid && act.bad;
        end
    end
endmodule

// File: rtl/tfifo_cell_chk.sv
module tfifo_cell_chk #(
    parameter int DEPTH  = 8,
    parameter int MASK_W = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic [PTR_W-1:0]  ptr,
    input logic [IDX_W-1:0]  head,
    input logic              e_flag,
    input logic              f_flag,
    input logic [MASK_W-1:0] blk_mask,
    input logic [MASK_W-1:0] wake,
    input logic              rsp_stall,
    input logic              rsp_error,
    input logic [63:0]       rsp_rdata
);
    // R6
    ptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        32'(ptr) <= DEPTH);

    // R8
    stall_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_stall |-> (ptr == $past(ptr) && head == $past(head) && rsp_rdata == '0));

    // R9
    wake_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (wake != '0) |-> (blk_mask == '0));

    // R11
    bad_view_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_error |-> (rsp_rdata == '0 && !rsp_stall));

    // R7
    push_clears_e_chk: assert property (@(posedge clk) disable iff (rst)
        (ptr > $past(ptr)) |-> !e_flag);

    // R6
    pop_clears_f_chk: assert property (@(posedge clk) disable iff (rst)
        (ptr < $past(ptr)) |-> !f_flag);
endmodule

bind tfifo_cell tfifo_cell_chk #(.DEPTH(DEPTH), .MASK_W(MASK_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ptr       (ptr_q),
    .head      (head_q),
    .e_flag    (flg_q.e),
    .f_flag    (flg_q.f),
    .blk_mask  (blk_mask),
    .wake      (wake_mask),
    .rsp_stall (rsp_stall),
    .rsp_error (rsp_error),
    .rsp_rdata (rsp_rdata)
);

// File: tb/test_tfifo_cell.sv
`timescale 1ns/1ps
module test_tfifo_cell;
    localparam int DEPTH  = 8;
    localparam int MASK_W = 64;
    localparam int CODE   = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [5:0]  req_id = '0;
    logic [3:0]  req_view = '0;
    logic        req_write = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid, rsp_stall, rsp_error;
    logic [63:0] rsp_rdata;
    logic [63:0] wake_mask;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [63:0] m_data [DEPTH];
    int          m_head, m_ptr;
    bit          m_e, m_f, m_t;
    logic [63:0] m_mask;

    always #4 clk = ~clk;

    tfifo_cell #(.DEPTH(DEPTH), .MASK_W(MASK_W)) i_tfifo_cell (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_id(req_id),
        .req_view(req_view), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_stall(rsp_stall),
        .rsp_error(rsp_error), .wake_mask(wake_mask)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string rd_tag(input int view, input bit wr);
        case (view)
            0: return wr ? "R5" : "R4";
            1: return wr ? "R3" : "R2";
            2, 3: return wr ? "R7" : "R6";
            default: return "R11";
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) m_data[i] = '0;
        m_head = 0; m_ptr = 0; m_e = 1; m_f = 0; m_t = 0; m_mask = '0;
    endtask

    // Called at a falling edge; compares one falling edge later.
    task automatic req(input int id, input int view, input bit wr, input logic [63:0] wd);
        logic [63:0] e_rd, e_wake;
        bit e_stall, e_err, blocking;
        e_rd = '0; e_wake = '0; e_stall = 0; e_err = 0;
        case (view)
            0: begin
                if (!wr) e_rd = m_data[m_head];
                else if (m_ptr > 0) m_data[(m_head + m_ptr - 1) % DEPTH] = wd;
            end
            1: begin
                if (!wr) e_rd = 64'(m_e) | (64'(m_f) << 1) | (64'(m_t) << 16) | (64'd1 << 17)
                              | (64'(m_ptr) << 18) | (64'(CODE) << 28);
                else begin m_t = wd[16]; m_e = wd[0]; m_f = wd[1]; end
            end
            2, 3: begin
                blocking = (view == 2);
                if (blocking && (wr ? m_f : m_e)) begin
                    e_stall = 1;
                    m_mask[id] = 1'b1;
                end else begin
                    e_wake = m_mask;
                    m_mask = '0;
                    if (wr) begin
                        if (m_ptr < DEPTH) begin
                            m_data[(m_head + m_ptr) % DEPTH] = wd;
                            m_ptr++; m_e = 0;
                        end
                        if (m_ptr == DEPTH) m_f = 1;
                    end else begin
                        if (m_ptr > 0) begin
                            e_rd = m_data[m_head];
                            m_head = (m_head + 1) % DEPTH;
                            m_ptr--; m_f = 0;
                        end
                        if (m_ptr == 0) m_e = 1;
                    end
                end
            end
            default: e_err = 1;
        endcase
        req_valid = 1'b1; req_id = 6'(id); req_view = 4'(view);
        req_write = wr; req_wdata = wd;
        @(negedge clk);
        chk(rsp_valid === 1'b1, "R12 rsp_valid", 64'(rsp_valid), 64'd1);
        chk(rsp_rdata === e_rd, rd_tag(view, wr), rsp_rdata, e_rd);
        chk(rsp_stall === e_stall, "R8 stall", 64'(rsp_stall), 64'(e_stall));
        chk(wake_mask === e_wake, "R9 wake", wake_mask, e_wake);
        chk(rsp_error === e_err, "R11 error", 64'(rsp_error), 64'(e_err));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 idle outputs after reset
        chk(rsp_valid === 1'b0 && rsp_stall === 1'b0 && rsp_error === 1'b0, "R1 idle flags",
            {61'd0, rsp_valid, rsp_stall, rsp_error}, 64'd0);
        chk(wake_mask === '0, "R1 wake idle", wake_mask, 64'd0);
        req(1, 1, 0, '0);                 // R1/R2 reset tag word
        req(1, 0, 0, '0);                 // R1/R4 zero entry
        req(2, 0, 1, 64'hDEAD);           // R5 ignored when empty
        req(2, 0, 0, '0);                 // R5 check entry untouched
        req(3, 3, 0, '0);                 // R10 try read empty
        req(5, 2, 0, '0);                 // R8 stall
        req(63, 2, 0, '0);                // R8 stall
        req(9, 3, 1, 64'h1111);           // R9 release 5 and 63, R7 push
        for (int i = 0; i < DEPTH - 1; i++) req(i, 3, 1, 64'h100 + 64'(i));
        req(1, 1, 0, '0);                 // R2 full tag
        req(7, 2, 1, 64'hBAD);            // R8 blocking write full
        req(8, 3, 1, 64'hBAD2);           // R10 dropped, R9 release 7
        req(4, 0, 1, 64'hCAFE);           // R5 overwrite newest
        req(4, 0, 0, '0);                 // R4 head no pop
        req(4, 0, 0, '0);                 // R4 repeat same
        req(4, 1, 1, 64'h0001_0000);      // R3 set T, clear E/F
        req(4, 1, 0, '0);                 // R3 observe
        for (int i = 0; i < DEPTH + 1; i++) req(6, 2, 0, '0); // R6 drain, wrap
        req(4, 1, 0, '0);                 // R6 empty tag
        req(4, 7, 1, 64'hFFFF);           // R11 write ignored
        req(4, 15, 0, '0);                // R11 read zero
        req(4, 1, 0, '0);                 // R11 tag unchanged
        for (int n = 0; n < 800; n++) begin
            int r, v;
            r = int'($urandom % 16);
            v = (r < 14) ? (r % 4) : 4 + int'($urandom % 12);
            req(int'($urandom % 64), v, bit'($urandom % 2), {$urandom, $urandom});
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R12 no response", 64'(rsp_valid), 64'd0);
        chk(wake_mask === '0, "R9 pulse one cycle", wake_mask, 64'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule